// File: doc/BRIEF.md
# Mesochronous Dual-Phase Data Receiver

This block accepts a data word from a transmitter whose clock has the same nominal frequency as the local receive clock but an unknown phase that drifts slowly. Every incoming word is caught twice: once on the rising edge of the receive clock and once on the falling edge. The falling-edge copy is moved to the next rising edge, so both copies line up on the same rising edge. A companion toggle line from the transmitter inverts once per transmit cycle. The block samples it in the same dual-phase way to find which half of the receive period holds the transmitter's launch edge.

A phase observer turns each cycle's toggle samples into a preference for one copy. A selector with hysteresis commits to that copy only after the same opposing preference has been seen for `HYST` consecutive cycles. The chosen word goes through one output register. The selection and a one-cycle change flag are exposed, so downstream logic can tolerate the single duplicated or skipped word that a switch of copy can cause.

Top module: `meso_rx`

## Requirements
- R1: While rst_ni is low, data_o is 0, valid_o is 0, sel_o is 0 and sel_chg_o is 0.
- R2: While sel_o is steady and the phase stays inside one half period, every word presented on tx_data_i appears exactly once on data_o, in order, while valid_o is 1.
- R3: A toggle transition that falls after a receive rising edge and before the next falling edge makes the falling copy preferred (sel_o = 1). A transition after a falling edge and before the next rising edge makes the rising copy preferred (sel_o = 0).
- R4: sel_o changes only after HYST consecutive cycles of observations that prefer the other copy. A shorter run, or any cycle with no toggle transition, restarts the count.
- R5: sel_chg_o is a single-cycle pulse, high exactly in the first cycle in which sel_o shows its new value.
- R6: valid_o stays 0 after reset until HYST cycles with a toggle transition have been observed. It then goes to 1 and stays at 1 until the next reset.
- R7: A duplicated or skipped output word occurs only within 2*HYST cycles of a sel_chg_o pulse.
- R8: With tx_tog_i held constant, valid_o stays 0 and sel_o keeps its reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local receive clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_data_i | input | DW | Data word launched on the transmitter clock |
| tx_tog_i | input | 1 | Transmitter toggle, inverts every transmit cycle |
| data_o | output | DW | Retimed data word |
| valid_o | output | 1 | High once the first decision window has completed |
| sel_o | output | 1 | Current copy: 0 = rising-edge copy, 1 = falling-edge copy |
| sel_chg_o | output | 1 | One-cycle pulse on each change of sel_o |

## Verification
A fault in the observer's half-period decode shows at the ports as a selection that points at the wrong copy. Within HYST plus two cycles of a phase change, sel_o disagrees with the half that holds the launch edge, and the output sequence develops unflagged repeats or gaps as the sampler crosses the data edge. A broken hysteresis counter shows as sel_chg_o pulses during short phase dithers, or as a switch that comes early or never comes. A lost alignment stage in the falling path shows as an output sequence that jumps without a flag as soon as that copy is chosen.

// File: rtl/meso_rx_pkg.sv
package meso_rx_pkg;
  localparam logic SEL_RISE = 1'b0;
  localparam logic SEL_FALL = 1'b1;

  typedef enum logic [1:0] {
    OBS_NONE = 2'd0,
    OBS_RISE = 2'd1,
    OBS_FALL = 2'd2
  } obs_e;
endpackage

// File: rtl/meso_rx_capture.sv
module meso_rx_capture #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] neg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rise_o <= '0;
    else         rise_o <= d_i;
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) neg_q <= '0;
    else         neg_q <= d_i;
  end

  // move falling sample onto the rising edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fall_o <= '0;
    else         fall_o <= neg_q;
  end
endmodule

// File: rtl/meso_rx_observer.sv
module meso_rx_observer
  import meso_rx_pkg::*;
#(
  parameter int unsigned HYST = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tog_rise_i,
  input  logic tog_fall_i,
  output logic sel_o,
  output logic chg_o,
  output logic win_done_o
);
  localparam int unsigned CW = $clog2(HYST + 1);

  logic          tog_prev_q;
  logic          early, late;
  obs_e          obs;
  logic          pref, opp;
  logic [CW-1:0] cnt_q, win_cnt_q;
  logic          sel_q, chg_q, win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tog_prev_q <= 1'b0;
    else         tog_prev_q <= tog_rise_i;
  end

  // early: edge between previous rise and the fall; late: between fall and this rise
  assign early = tog_fall_i ^ tog_prev_q;
  assign late  = tog_fall_i ^ tog_rise_i;

  always_comb begin
    obs = OBS_NONE;
    if (early && !late)      obs = OBS_FALL;
    else if (late && !early) obs = OBS_RISE;
  end

  assign pref = (obs == OBS_FALL) ? SEL_FALL : SEL_RISE;
  assign opp  = (obs != OBS_NONE) && (pref != sel_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sel_q <= SEL_RISE;
      chg_q <= 1'b0;
    end else begin
      chg_q <= 1'b0;
      if (!opp) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(HYST - 1)) begin
        cnt_q <= '0;
        sel_q <= pref;
        chg_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_cnt_q <= '0;
      win_q     <= 1'b0;
    end else if (!win_q && obs != OBS_NONE) begin
      win_cnt_q <= win_cnt_q + 1'b1;
      if (win_cnt_q == CW'(HYST - 1)) win_q <= 1'b1;
    end
  end

  assign sel_o      = sel_q;
  assign chg_o      = chg_q;
  assign win_done_o = win_q;

  // R4
  sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !opp |=> $stable(sel_q));
  // R4
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(HYST));
  // R5
  chg_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_q |=> !chg_q);
  // R5
  chg_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q != $past(sel_q)) |-> chg_q);
  // R6
  win_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_q |=> win_q);
endmodule

// File: rtl/meso_rx.sv
module meso_rx
  import meso_rx_pkg::*;
#(
  parameter int unsigned DW   = 8,
  parameter int unsigned HYST = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] tx_data_i,
  input  logic          tx_tog_i,
  output logic [DW-1:0] data_o,
  output logic          valid_o,
  output logic          sel_o,
  output logic          sel_chg_o
);
  logic [DW-1:0] dat_rise, dat_fall, dat_mux;
  logic          tog_rise, tog_fall;
  logic          sel, win_done;

  meso_rx_capture #(.W(DW)) u_cap_data (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (tx_data_i),
    .rise_o(dat_rise),
    .fall_o(dat_fall)
  );

  meso_rx_capture #(.W(1)) u_cap_tog (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (tx_tog_i),
    .rise_o(tog_rise),
    .fall_o(tog_fall)
  );

  meso_rx_observer #(.HYST(HYST)) u_obs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tog_rise_i(tog_rise),
    .tog_fall_i(tog_fall),
    .sel_o     (sel),
    .chg_o     (sel_chg_o),
    .win_done_o(win_done)
  );

  assign dat_mux = (sel == SEL_FALL) ? dat_fall : dat_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      data_o  <= dat_mux;
      valid_o <= win_done;
    end
  end

  assign sel_o = sel;

  // R6
  valid_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o);
  // R2
  agree_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_rise == dat_fall) |=> (data_o == $past(dat_rise)));
endmodule

// File: tb/meso_rx_bench.sv
module meso_rx_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int DW   = 8;
  localparam int HYST = 16;
  localparam int WIN  = 2 * HYST;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [DW-1:0] tx_data_i = '0;
  logic          tx_tog_i = 1'b0;
  logic [DW-1:0] data_o;
  logic          valid_o, sel_o, sel_chg_o;

  meso_rx #(.DW(DW), .HYST(HYST)) u_meso_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tx_data_i(tx_data_i),
    .tx_tog_i (tx_tog_i),
    .data_o   (data_o),
    .valid_o  (valid_o),
    .sel_o    (sel_o),
    .sel_chg_o(sel_chg_o)
  );

  always #5 clk_i = ~clk_i;

  int n_chk = 0, n_err = 0;
  int cyc = 0, chg_cnt = 0, last_chg = -1000;
  bit tog_en = 0, mon_en = 0, synced = 0, pend = 0;
  int pend_cyc = 0;
  real tx_next = 7.3, tx_adj = 0.0;
  logic [DW-1:0] exp_q[$];
  logic [DW-1:0] last_w;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // driver: transmitter clock with adjustable phase
  initial begin
    forever begin
      #(tx_next - $realtime);
      tx_data_i = tx_data_i + 1'b1;
      exp_q.push_back(tx_data_i);
      if (exp_q.size() > 64) void'(exp_q.pop_front());
      if (tog_en) tx_tog_i = ~tx_tog_i;
      tx_next = tx_next + 10.0 + tx_adj;
      tx_adj  = 0.0;
    end
  end

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      cyc++;
      if (rst_ni && sel_chg_o) begin
        chg_cnt++;
        last_chg = cyc;
        if (pend && cyc - pend_cyc <= WIN) begin
          pend = 0;
          chk(1'b1, "R7", 0, 0);
        end
      end
      if (pend && cyc - pend_cyc > WIN) begin
        pend = 0;
        chk(1'b0, "R7 unflagged slip", pend_cyc, last_chg);
      end
      if (mon_en && valid_o) begin
        if (!synced) begin
          while (exp_q.size() > 0 && exp_q[0] != data_o) void'(exp_q.pop_front());
          chk(exp_q.size() > 0, "R2 sync", int'(data_o), -1);
          if (exp_q.size() > 0) begin
            last_w = exp_q.pop_front();
            synced = 1;
          end
        end else if (exp_q.size() > 0 && data_o == exp_q[0]) begin
          last_w = exp_q.pop_front();
          chk(1'b1, "R2", 0, 0);
        end else begin
          bit slip;
          slip = 0;
          if (data_o == last_w) slip = 1;
          else if (exp_q.size() > 1 && data_o == exp_q[1]) begin
            void'(exp_q.pop_front());
            last_w = exp_q.pop_front();
            slip = 1;
          end
          if (!slip)
            chk(1'b0, "R2", int'(data_o), (exp_q.size() > 0) ? int'(exp_q[0]) : -1);
          else if (cyc - last_chg <= WIN)
            chk(1'b1, "R7", 0, 0);
          else begin
            pend = 1;
            pend_cyc = cyc;
          end
        end
      end
    end
  end

  bit done = 0;
  initial begin
    #(200000 * 10);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int c0;
    repeat (3) @(posedge clk_i);
    #1;
    // R1
    chk(data_o == '0, "R1 data", int'(data_o), 0);
    chk(valid_o == 1'b0, "R1 valid", int'(valid_o), 0);
    chk(sel_o == 1'b0, "R1 sel", int'(sel_o), 0);
    chk(sel_chg_o == 1'b0, "R1 chg", int'(sel_chg_o), 0);
    @(negedge clk_i) rst_ni = 1'b1;

    // R8: idle toggle
    repeat (100) @(posedge clk_i);
    #1;
    chk(valid_o == 1'b0, "R8 valid", int'(valid_o), 0);
    chk(sel_o == 1'b0, "R8 sel", int'(sel_o), 0);

    // launch edge in first half -> falling copy (R3), after HYST (R4, R6)
    @(negedge clk_i);
    tog_en = 1;
    mon_en = 1;
    c0 = chg_cnt;
    repeat (HYST - 4) @(posedge clk_i);
    #1;
    chk(sel_o == 1'b0, "R4 early", int'(sel_o), 0);
    chk(valid_o == 1'b0, "R6 early", int'(valid_o), 0);
    repeat (14) @(posedge clk_i);
    #1;
    chk(sel_o == 1'b1, "R3 first half", int'(sel_o), 1);
    chk(chg_cnt - c0 == 1, "R5 one pulse", chg_cnt - c0, 1);
    chk(valid_o == 1'b1, "R6 window", int'(valid_o), 1);

    // dither across the boundary, shorter than HYST (R4)
    mon_en = 0;
    c0 = chg_cnt;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk_i) tx_adj = -5.0;
      repeat (6) @(posedge clk_i);
      @(negedge clk_i) tx_adj = 5.0;
      repeat (6) @(posedge clk_i);
    end
    repeat (4) @(posedge clk_i);
    #1;
    chk(chg_cnt == c0, "R4 dither", chg_cnt - c0, 0);
    chk(sel_o == 1'b1, "R4 dither sel", int'(sel_o), 1);
    chk(valid_o == 1'b1, "R6 sticky", int'(valid_o), 1);

    // launch edge in second half -> rising copy (R3)
    c0 = chg_cnt;
    @(negedge clk_i) tx_adj = -5.0;
    repeat (40) @(posedge clk_i);
    #1;
    chk(sel_o == 1'b0, "R3 second half", int'(sel_o), 0);
    chk(chg_cnt - c0 == 1, "R5 one pulse", chg_cnt - c0, 1);

    // slow sweep over two full periods (R2, R7, R3)
    synced = 0;
    mon_en = 1;
    c0 = chg_cnt;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk_i) tx_adj = 0.4;
      repeat (60) @(posedge clk_i);
    end
    repeat (2 * WIN) @(posedge clk_i);
    #1;
    chk(chg_cnt - c0 == 4, "R3 sweep changes", chg_cnt - c0, 4);
    chk(pend == 0, "R7 pending", int'(pend), 0);
    chk(synced == 1, "R2 synced", int'(synced), 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule